// File: doc/BRIEF.md
# Multi-mode asynchronous serial transmitter

This block turns one data word into an asynchronous serial frame on a single transmit line. The line rests high. A frame starts with one low start bit. The data bits follow, least significant bit first. After the data come an optional extra bit and then one or two high stop bits. The length of each bit is set by an external baud tick enable: every bit lasts a fixed number of ticks, 16 by default. The block does not make its own baud rate.

A 2-bit mode input selects how the frame configuration inputs are applied:
- Mode 0 (and the unused code 2) is the plain asynchronous format. The extra bit is an optional even or odd parity bit.
- Mode 1 is the multiprocessor format. The extra bit is always present and marks the frame as an address frame or a data frame. Parity is never sent in this mode.
- Mode 3 is a fixed bus format. It always sends 8 data bits, no parity and one stop bit, whatever the configuration inputs hold.

Words are loaded through a valid/ready handshake. The data word and the whole configuration are captured at the moment of acceptance. A busy output is high for as long as a frame is on the line. Clearing the transmit enable during a frame abandons the frame at once.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and at any time no frame is in progress, `tx_line` is 1 and `busy` is 0.
- R2: `in_ready` is 1 exactly when `tx_enable` is 1 and `busy` is 0. A word is taken only on a clock edge where `in_valid` and `in_ready` are both 1. While `in_ready` is 0, `in_valid` has no effect and `busy` stays 0.
- R3: The cycle after acceptance, `busy` is 1 and the line shows the start bit (0). The data bits follow least significant bit first. In modes 0 (`mode`=2'b00) and 2 (`mode`=2'b10), `cfg_len8`=1 sends 8 data bits and `cfg_len8`=0 sends 7 (bits 0..6).
- R4: Each bit stays on the line for exactly 16 clock edges at which `tick_en` is 1. Cycles without a tick do not advance the frame.
- R5: In modes 0 and 2 with `cfg_par_en`=1, one parity bit follows the data bits. With `cfg_par_odd`=0, the total number of ones in the sent data bits plus the parity bit is even. With `cfg_par_odd`=1 it is odd.
- R6: Outside mode 3, `cfg_two_stop`=0 gives one high stop bit and `cfg_two_stop`=1 gives two.
- R7: In mode 1 (`mode`=2'b01), one marker bit equal to `cfg_addr` follows the data bits, and no parity bit is sent whatever `cfg_par_en` holds.
- R8: In mode 3 (`mode`=2'b11), the frame always has 8 data bits, no parity bit and one stop bit, whatever `cfg_len8`, `cfg_par_en` and `cfg_two_stop` hold.
- R9: If `tx_enable` is 0 at a clock edge while `busy` is 1, then after that edge `busy` is 0 and `tx_line` is 1. The abandoned frame is never resumed.
- R10: `busy` stays 1 until the edge that carries the last stop bit's 16th tick. After that edge, `busy` is 0 and `in_ready` is 1 again if `tx_enable` is 1.
- R11: Data and configuration inputs are sampled only at acceptance. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Baud tick enable, one clock wide per tick |
| tx_enable | input | 1 | Transmit enable; 0 aborts a running frame |
| mode | input | 2 | Operating mode: 0 normal, 1 multiprocessor, 2 as 0, 3 fixed format |
| cfg_par_en | input | 1 | Parity enable (modes 0 and 2) |
| cfg_par_odd | input | 1 | Parity polarity: 0 even, 1 odd |
| cfg_two_stop | input | 1 | Stop length: 0 one bit, 1 two bits |
| cfg_len8 | input | 1 | Data length: 1 eight bits, 0 seven bits |
| cfg_addr | input | 1 | Marker value in mode 1: 1 address, 0 data |
| in_valid | input | 1 | Word offered for transmission |
| in_data | input | 8 | Word to transmit |
| in_ready | output | 1 | Block can accept a word |
| busy | output | 1 | A frame is on the line |
| tx_line | output | 1 | Serial output, idles high |

## Verification
The bench drives the fixed-format mode with every override bit set. A design that did not force the format would send 7 data bits, a parity bit or a second stop bit there. It drives multiprocessor mode with parity enabled, which exposes a design that sends parity in place of the marker, or both. Ticks arrive on an irregular pattern and every cycle is sampled, so a bit counted from clock cycles instead of ticks, or cut off at 15 ticks, shows up as a bit at the wrong time. Frames are also aborted part-way, and the configuration and data are scrambled right after acceptance. This catches designs that keep sending after the enable falls, or that read their settings live instead of from the captured copy.

// File: rtl/utx_pkg.sv
package utx_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_MULTI  = 2'b01,
        MODE_SPARE  = 2'b10,
        MODE_FIXED  = 2'b11
    } utx_mode_e;

    // Frame format after the mode overrides have been applied
    typedef struct packed {
        logic len_full;      // all data bits sent, else one fewer
        logic extra_en;      // an extra bit follows the data
        logic extra_marker;  // extra bit is the marker, else parity
        logic marker_val;
        logic par_odd;
        logic two_stop;
    } utx_fmt_t;

endpackage

// File: rtl/utx_cfg_resolve.sv
module utx_cfg_resolve
    import utx_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    input  logic       len8,
    input  logic       addr,
    output utx_fmt_t   fmt
);
    utx_mode_e mode_e;

    always_comb begin
        mode_e = utx_mode_e'(mode);
        fmt.len_full     = len8;
        fmt.extra_en     = par_en;
        fmt.extra_marker = 1'b0;
        fmt.marker_val   = addr;
        fmt.par_odd      = par_odd;
        fmt.two_stop     = two_stop;
        case (mode_e)
            MODE_MULTI: begin
                fmt.extra_en     = 1'b1;
                fmt.extra_marker = 1'b1;
            end
            MODE_FIXED: begin
                fmt.len_full = 1'b1;
                fmt.extra_en = 1'b0;
                fmt.two_stop = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/utx_frame_build.sv
module utx_frame_build
    import utx_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned FRAME_W = DATA_W + 4,
    parameter int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  utx_fmt_t           fmt,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   nbits
);
    localparam int unsigned SHORT_W = DATA_W - 1;

    logic [DATA_W-1:0] used;
    logic              extra_bit;
    int unsigned       dlen;

    always_comb begin
        dlen = fmt.len_full ? DATA_W : SHORT_W;
        used = fmt.len_full ? data : {1'b0, data[SHORT_W-1:0]};
        extra_bit = fmt.extra_marker ? fmt.marker_val : ((^used) ^ fmt.par_odd);

        // Stop bits and unused tail positions stay high
        frame    = '1;
        frame[0] = 1'b0;
        for (int j = 0; j < DATA_W; j++) begin
            if (j < dlen)
                frame[j+1] = data[j];
            else if (j == dlen && fmt.extra_en)
                frame[j+1] = extra_bit;
        end
        if (fmt.len_full && fmt.extra_en)
            frame[DATA_W+1] = extra_bit;

        nbits = CNT_W'(1 + dlen + (fmt.extra_en ? 1 : 0) + 1 + (fmt.two_stop ? 1 : 0));
    end
endmodule

// File: rtl/utx_tick_div.sv
module utx_tick_div #(
    parameter int unsigned TICKS = 16,
    parameter int unsigned TW    = (TICKS > 1) ? $clog2(TICKS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick_en,
    output logic bit_end
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        bit_end = run && tick_en && (cnt_q == TW'(TICKS - 1));
        cnt_d   = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (tick_en)
            cnt_d = bit_end ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import utx_pkg::*;
#(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              tx_enable,
    input  logic [1:0]        mode,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_len8,
    input  logic              cfg_addr,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              busy,
    output logic              tx_line
);
    localparam int unsigned FRAME_W = DATA_W + 4;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   left;
    } tx_state_t;

    tx_state_t          st_d, st_q;
    utx_fmt_t           fmt;
    logic [FRAME_W-1:0] built;
    logic [CNT_W-1:0]   built_n;
    logic               bit_end;
    logic               accept;

    utx_cfg_resolve u_cfg (
        .mode     (mode),
        .par_en   (cfg_par_en),
        .par_odd  (cfg_par_odd),
        .two_stop (cfg_two_stop),
        .len8     (cfg_len8),
        .addr     (cfg_addr),
        .fmt      (fmt)
    );

    utx_frame_build #(
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) u_build (
        .data  (in_data),
        .fmt   (fmt),
        .frame (built),
        .nbits (built_n)
    );

    utx_tick_div #(
        .TICKS (TICKS_PER_BIT)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.busy),
        .tick_en (tick_en),
        .bit_end (bit_end)
    );

    assign in_ready = tx_enable && !st_q.busy;
    assign accept   = in_valid && in_ready;
    assign busy     = st_q.busy;
    assign tx_line  = !st_q.busy || st_q.frame[0];

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (!tx_enable) begin
                st_d.busy  = 1'b0;
                st_d.frame = '1;
                st_d.left  = '0;
            end else if (bit_end) begin
                st_d.frame = {1'b1, st_q.frame[FRAME_W-1:1]};
                st_d.left  = st_q.left - 1'b1;
                if (st_q.left == CNT_W'(1))
                    st_d.busy = 1'b0;
            end
        end else if (accept) begin
            st_d.busy  = 1'b1;
            st_d.frame = built;
            st_d.left  = built_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy  <= 1'b0;
            st_q.frame <= '1;
            st_q.left  <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_en,
    input logic tx_enable,
    input logic in_valid,
    input logic in_ready,
    input logic busy,
    input logic tx_line
);
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

    p_ready_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (tx_enable && !busy));

    p_no_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready && !busy) |=> !busy);

    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && !tx_line));

    p_hold_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_enable && !tick_en) |=> (busy && $stable(tx_line)));

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_enable) |=> (!busy && tx_line));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (.*);

// File: tb/sim_uart_frame_tx.sv
`timescale 1ns/1ps
module sim_uart_frame_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       tx_enable = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       cfg_len8 = 1'b1, cfg_addr = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, busy, tx_line;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    uart_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tx_enable(tx_enable),
        .mode(mode), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_len8(cfg_len8), .cfg_addr(cfg_addr),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .busy(busy), .tx_line(tx_line)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected frame, built from the requirements
    function automatic void model(input logic [7:0] d, input logic pe, input logic po,
                                  input logic ts, input logic l8, input logic ad,
                                  input logic [1:0] md, output logic [11:0] bits,
                                  output string tags [12], output int n);
        bit m3 = (md == 2'b11);
        bit m1 = (md == 2'b01);
        int dl = (m3 || l8) ? 8 : 7;
        logic p = po;
        n = 0;
        bits = '1;
        bits[n] = 1'b0; tags[n] = m3 ? "R8" : "R3"; n++;
        for (int i = 0; i < dl; i++) begin
            bits[n] = d[i]; tags[n] = m3 ? "R8" : "R3"; n++;
            p = p ^ d[i];
        end
        if (m1) begin
            bits[n] = ad; tags[n] = "R7"; n++;
        end else if (pe && !m3) begin
            bits[n] = p; tags[n] = "R5"; n++;
        end
        for (int s = 0; s < ((!m3 && ts) ? 2 : 1); s++) begin
            bits[n] = 1'b1; tags[n] = m3 ? "R8" : "R6"; n++;
        end
    endfunction

    task automatic run_frame(input logic [7:0] d, input logic pe, input logic po,
                             input logic ts, input logic l8, input logic ad,
                             input logic [1:0] md, input bit scramble, input int abort_at);
        logic [11:0] bits;
        string       tags [12];
        int          n;
        int          total = 0;
        model(d, pe, po, ts, l8, ad, md, bits, tags, n);
        @(negedge clk);
        tick_en = 1'b0;
        in_data = d; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
        cfg_len8 = l8; cfg_addr = ad; mode = md; in_valid = 1'b1;
        check("R2 ready when idle", {7'd0, in_ready}, 8'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (scramble) begin // R11: inputs change after acceptance
            in_data = 8'($urandom); mode = 2'($urandom);
            {cfg_par_en, cfg_par_odd, cfg_two_stop, cfg_len8, cfg_addr} = 5'($urandom);
        end
        for (int b = 0; b < n; b++) begin
            int cnt = 0;
            while (cnt < 16) begin
                if (abort_at >= 0 && total == abort_at) begin
                    tick_en = 1'b0;
                    tx_enable = 1'b0;
                    @(posedge clk);
                    @(negedge clk);
                    check("R9 busy after abort", {7'd0, busy}, 8'd0);
                    check("R9 line after abort", {7'd0, tx_line}, 8'd1);
                    check("R2 ready with enable low", {7'd0, in_ready}, 8'd0);
                    tx_enable = 1'b1;
                    repeat (3) @(negedge clk);
                    check("R9 not resumed", {7'd0, busy}, 8'd0);
                    return;
                end
                check(scramble ? {tags[b], "/R11 bit"} : {tags[b], " bit"},
                      {7'd0, tx_line}, {7'd0, bits[b]});
                check("R10 busy in frame", {7'd0, busy}, 8'd1);
                check("R2 not ready in frame", {7'd0, in_ready}, 8'd0);
                tick_en = (($urandom % 4) != 0);
                @(posedge clk);
                if (tick_en) begin
                    cnt++;
                    total++;
                end
                @(negedge clk);
            end
        end
        tick_en = 1'b0;
        check("R10 busy after last stop (R4 length)", {7'd0, busy}, 8'd0);
        check("R1 line idle", {7'd0, tx_line}, 8'd1);
        check("R10 ready again", {7'd0, in_ready}, 8'd1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset line", {7'd0, tx_line}, 8'd1);
        check("R1 reset busy", {7'd0, busy}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle ready", {7'd0, in_ready}, 8'd1);

        // R2: valid ignored while enable is low
        tx_enable = 1'b0; in_valid = 1'b1; in_data = 8'h3C;
        repeat (4) begin
            @(negedge clk);
            check("R2 ready low when disabled", {7'd0, in_ready}, 8'd0);
            check("R2 no frame when disabled", {7'd0, busy}, 8'd0);
            check("R2 line idle when disabled", {7'd0, tx_line}, 8'd1);
        end
        in_valid = 1'b0; tx_enable = 1'b1;

        // Directed corner cases
        run_frame(8'h00, 1, 1, 0, 1, 0, 2'b00, 0, -1); // R5 odd parity of zero
        run_frame(8'h07, 1, 0, 1, 1, 0, 2'b00, 0, -1); // R5 even, R6 two stops
        run_frame(8'hFF, 0, 0, 0, 0, 0, 2'b10, 0, -1); // R3 seven bits, mode 2
        run_frame(8'hA5, 1, 1, 1, 0, 1, 2'b11, 0, -1); // R8 overrides
        run_frame(8'h81, 1, 0, 0, 1, 1, 2'b01, 0, -1); // R7 address marker
        run_frame(8'h42, 1, 1, 1, 0, 0, 2'b01, 0, -1); // R7 data marker, no parity
        run_frame(8'h5A, 1, 0, 1, 1, 0, 2'b00, 0, 40);  // R9 mid-frame abort
        run_frame(8'hC3, 0, 0, 0, 1, 0, 2'b00, 1, -1); // R11 scramble

        for (int k = 0; k < 40; k++) begin
            run_frame(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                      (k % 8 == 7) ? int'($urandom % 150) : -1);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule